// File: doc/BRIEF.md
# Byte-Lane Static RAM Mode Decoder

This block is the control core of an asynchronous static RAM, recast as a clocked and synthesizable model so that a memory controller can be verified against it. It takes two chip selects (one active low, one active high), an active-low write strobe, an active-low read enable and two active-low lane enables. It resolves them into one of four modes: standby, read, write, or selected with outputs held off. From that mode it derives per-lane write strobes into a small inferred array and per-lane drive enables for the data outputs.

A width strap picks the organisation. With the strap high, the array holds 16-bit words and each 8-bit lane is enabled separately. With the strap low, the array is byte addressed. The top data input pin then serves as the least significant byte-address bit, the lane enables and the upper data pins other than the top one are ignored, and bytes travel on the low eight data pins.

The model samples its inputs on each rising clock edge. A write takes effect at that edge. Mode, drive enables and read data appear one cycle later. The array depth is a parameter, and word addresses wrap modulo that depth, so small simulations keep the full address width and the same decode.

Top module: `sram_mode_core`

## Requirements
- R1: While reset is asserted and after it is released, with no edge yet sampled, mode_o is 2'b00 (standby), dq_drive is 2'b00 and dq_out is zero.
- R2: If sel1_n is high or sel2 is low, or if wide_strap is high and both upper_n and lower_n are high, the next cycle shows mode 2'b00 and dq_drive 2'b00, and no array byte is written.
- R3: Selected (sel1_n low, sel2 high) with wr_n high and rd_en_n low in word mode gives mode 2'b01 one cycle later. dq_drive[0] equals !lower_n and dq_drive[1] equals !upper_n. Each driven lane carries the stored byte: bits 7:0 from the low lane and bits 15:8 from the high lane.
- R4: Selected with wr_n low gives mode 2'b10 and dq_drive 2'b00 the next cycle, whatever rd_en_n is. In word mode only lanes whose enable is low are written, from dq_in[7:0] (low lane) and dq_in[15:8] (high lane). The other lane keeps its contents.
- R5: Selected with wr_n high and rd_en_n high gives mode 2'b11 and dq_drive 2'b00 for any lane-enable setting, and writes nothing.
- R6: With wide_strap low, the byte address is {addr, dq_in[15]}. dq_in[15]=0 selects the low byte of word addr and 1 selects its high byte. A write stores dq_in[7:0] there. A read returns the byte on dq_out[7:0] with dq_drive 2'b01.
- R7: With wide_strap low, upper_n, lower_n and dq_in[14:8] have no effect on mode, drive or stored data. Both lane enables high do not cause standby.
- R8: Every output lane whose dq_drive bit is 0 reads as all zeros on dq_out.
- R9: The word index is addr modulo DEPTH, so addr and addr+DEPTH reach the same word.
- R10: When the cycle after a write deselects the chip with wr_n high, dq_drive stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| sel1_n | input | 1 | Active-low chip select |
| sel2 | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write strobe |
| rd_en_n | input | 1 | Active-low output enable |
| upper_n | input | 1 | Active-low enable of the high lane (bits 15:8) |
| lower_n | input | 1 | Active-low enable of the low lane (bits 7:0) |
| wide_strap | input | 1 | 1: 16-bit word organisation; 0: byte organisation |
| addr | input | ADDR_W | Word address |
| dq_in | input | 2*LANE_W | Write data; top bit is the byte-address LSB in byte mode |
| dq_out | output | 2*LANE_W | Read data, zero on undriven lanes |
| dq_drive | output | 2 | Per-lane output drive enable |
| mode_o | output | 2 | 00 standby, 01 read, 10 write, 11 selected with outputs off |

## Verification
The hardest case to reach is byte mode. There, one data input pin is also an address bit, and the lane enables must be shown to do nothing. The stimulus writes two bytes into one word in byte mode, with both lane enables high and junk on the middle data pins. It reads each byte back in byte mode and then reads the whole word in word mode, which exposes the lane ordering. Writes attempted in standby and in the outputs-off mode are then shown to be dropped by reading the target word afterwards.

// File: rtl/sram_mode_pkg.sv
package sram_mode_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_READ  = 2'b01,
        MODE_WRITE = 2'b10,
        MODE_HOLD  = 2'b11
    } mode_e;

    // Result of the combinational control decode
    typedef struct packed {
        mode_e      mode;
        logic [1:0] lanes;     // lanes addressed by this access
    } dec_s;

    // Registered control state of the core
    typedef struct packed {
        mode_e      mode;
        logic [1:0] drive;     // per-lane output drive
        logic       narrow;    // byte organisation captured
        logic       byte_sel;  // byte-address LSB captured
    } state_s;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
    import sram_mode_pkg::*;
(
    input  logic sel1_n,
    input  logic sel2,
    input  logic wr_n,
    input  logic rd_en_n,
    input  logic upper_n,
    input  logic lower_n,
    input  logic wide_strap,
    input  logic top_bit,
    output dec_s dec
);
    logic       chip_on;
    logic [1:0] lanes;

    always_comb begin
        chip_on = !sel1_n && sel2;
        // word mode: lane enables; byte mode: top data pin picks the lane
        if (wide_strap) begin
            lanes = {!upper_n, !lower_n};
        end else begin
            lanes = top_bit ? 2'b10 : 2'b01;
        end

        dec.lanes = lanes;
        if (!chip_on || (lanes == 2'b00)) begin
            dec.mode = MODE_IDLE;
        end else if (!wr_n) begin
            dec.mode = MODE_WRITE;   // write wins over output enable
        end else if (!rd_en_n) begin
            dec.mode = MODE_READ;
        end else begin
            dec.mode = MODE_HOLD;
        end
    end
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
    parameter int LANE_W = 8,
    parameter int DEPTH  = 256,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[idx] <= wdata;
        end
        rdata_q <= mem_q[idx];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/sram_mode_core.sv
module sram_mode_core
    import sram_mode_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DEPTH  = 256,
    parameter int LANE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel1_n,
    input  logic                sel2,
    input  logic                wr_n,
    input  logic                rd_en_n,
    input  logic                upper_n,
    input  logic                lower_n,
    input  logic                wide_strap,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [2*LANE_W-1:0] dq_in,
    output logic [2*LANE_W-1:0] dq_out,
    output logic [1:0]          dq_drive,
    output logic [1:0]          mode_o
);
    localparam int LANES  = 2;
    localparam int DATA_W = LANES * LANE_W;
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    dec_s              dec;
    state_s            st_d, st_q;
    logic [IDX_W-1:0]  idx;
    logic [LANE_W-1:0] rd_lane [LANES];

    sram_mode_decode u_decode (
        .sel1_n     (sel1_n),
        .sel2       (sel2),
        .wr_n       (wr_n),
        .rd_en_n    (rd_en_n),
        .upper_n    (upper_n),
        .lower_n    (lower_n),
        .wide_strap (wide_strap),
        .top_bit    (dq_in[DATA_W-1]),
        .dec        (dec)
    );

    // Word index wraps at DEPTH; the upper address bits alias
    assign idx = addr[IDX_W-1:0];
    if (ADDR_W > IDX_W) begin : g_alias
        logic unused_hi_addr;
        assign unused_hi_addr = ^addr[ADDR_W-1:IDX_W];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] wdata;
        logic              wr_en;
        assign wdata = wide_strap ? dq_in[g*LANE_W +: LANE_W] : dq_in[LANE_W-1:0];
        assign wr_en = (dec.mode == MODE_WRITE) && dec.lanes[g];
        sram_lane_bank #(
            .LANE_W (LANE_W),
            .DEPTH  (DEPTH),
            .IDX_W  (IDX_W)
        ) u_bank (
            .clk   (clk),
            .wr_en (wr_en),
            .idx   (idx),
            .wdata (wdata),
            .rdata (rd_lane[g])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.mode     = dec.mode;
        st_d.narrow   = !wide_strap;
        st_d.byte_sel = dq_in[DATA_W-1];
        if (dec.mode != MODE_READ) begin
            st_d.drive = 2'b00;
        end else if (!wide_strap) begin
            st_d.drive = 2'b01;   // bytes always leave on the low lane
        end else begin
            st_d.drive = dec.lanes;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_IDLE, drive: 2'b00, narrow: 1'b0, byte_sel: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        logic [DATA_W-1:0] raw;
        if (st_q.narrow) begin
            raw = {{LANE_W{1'b0}}, (st_q.byte_sel ? rd_lane[1] : rd_lane[0])};
        end else begin
            raw = {rd_lane[1], rd_lane[0]};
        end
        for (int i = 0; i < LANES; i++) begin
            dq_out[i*LANE_W +: LANE_W] = st_q.drive[i] ? raw[i*LANE_W +: LANE_W] : '0;
        end
    end

    assign dq_drive = st_q.drive;
    assign mode_o   = st_q.mode;
endmodule

// File: rtl/sram_mode_checker.sv
module sram_mode_checker #(
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sel1_n,
    input logic                sel2,
    input logic                wr_n,
    input logic                rd_en_n,
    input logic                upper_n,
    input logic                lower_n,
    input logic                wide_strap,
    input logic [2*LANE_W-1:0] dq_out,
    input logic [1:0]          dq_drive,
    input logic [1:0]          mode_o
);
    logic on;
    assign on = !sel1_n && sel2;

    // R2: deselect leads to standby with no drive
    assert_deselect_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> (mode_o == 2'b00 && dq_drive == 2'b00));

    // R3: word-mode read drives exactly the enabled lanes
    assert_read_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (on && wr_n && !rd_en_n && wide_strap && !(upper_n && lower_n))
        |=> (mode_o == 2'b01 && dq_drive == ~$past({upper_n, lower_n})));

    // R4: any selected write never drives
    assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !wr_n && (!wide_strap || !(upper_n && lower_n)))
        |=> (mode_o == 2'b10 && dq_drive == 2'b00));

    // R5: selected, output enable off
    assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (on && wr_n && rd_en_n && (!wide_strap || !(upper_n && lower_n)))
        |=> (mode_o == 2'b11 && dq_drive == 2'b00));

    // R6: byte-mode read uses the low lane only
    assert_byte_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (on && wr_n && !rd_en_n && !wide_strap) |=> (dq_drive == 2'b01));

    // R8: undriven lanes read as zero
    assert_quiet_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((dq_drive[0] || dq_out[LANE_W-1:0] == '0) &&
                  (dq_drive[1] || dq_out[2*LANE_W-1:LANE_W] == '0)));

    // R10: deselect right after a write keeps outputs off
    assert_write_then_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10 && !on && wr_n) |=> (dq_drive == 2'b00));
endmodule

bind sram_mode_core sram_mode_checker #(.LANE_W(LANE_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel1_n     (sel1_n),
    .sel2       (sel2),
    .wr_n       (wr_n),
    .rd_en_n    (rd_en_n),
    .upper_n    (upper_n),
    .lower_n    (lower_n),
    .wide_strap (wide_strap),
    .dq_out     (dq_out),
    .dq_drive   (dq_drive),
    .mode_o     (mode_o)
);

// File: tb/tb_sram_mode_core.sv
module tb_sram_mode_core;
    localparam int ADDR_W = 19;
    localparam int DEPTH  = 256;
    localparam int LANE_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel1_n = 1'b1, sel2 = 1'b0, wr_n = 1'b1, rd_en_n = 1'b1;
    logic              upper_n = 1'b1, lower_n = 1'b1, wide_strap = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       dq_in = '0;
    logic [15:0]       dq_out;
    logic [1:0]        dq_drive, mode_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    sram_mode_core #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LANE_W(LANE_W)) dut (
        .clk(clk), .rst_n(rst_n), .sel1_n(sel1_n), .sel2(sel2), .wr_n(wr_n),
        .rd_en_n(rd_en_n), .upper_n(upper_n), .lower_n(lower_n),
        .wide_strap(wide_strap), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_drive(dq_drive), .mode_o(mode_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // drive one access, let the edge pass, return at the falling edge
    task automatic access(input logic s1n, input logic s2, input logic wn,
                          input logic on_n, input logic hn, input logic ln,
                          input logic wide, input logic [ADDR_W-1:0] a,
                          input logic [15:0] d);
        sel1_n = s1n; sel2 = s2; wr_n = wn; rd_en_n = on_n;
        upper_n = hn; lower_n = ln; wide_strap = wide; addr = a; dq_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [15:0] d,
                           input logic hn, input logic ln);
        access(1'b0, 1'b1, 1'b0, 1'b1, hn, ln, 1'b1, a, d);
    endtask

    task automatic rd_word(input logic [ADDR_W-1:0] a, input logic hn, input logic ln);
        access(1'b0, 1'b1, 1'b1, 1'b0, hn, ln, 1'b1, a, 16'h0000);
    endtask

    task automatic t_reset();
        check("R1 mode", {30'd0, mode_o}, 32'd0);
        check("R1 drive", {30'd0, dq_drive}, 32'd0);
        check("R1 data", {16'd0, dq_out}, 32'd0);
    endtask

    task automatic t_word_rw();
        wr_word(19'd5, 16'hA55A, 1'b0, 1'b0);
        check("R4 write mode", {30'd0, mode_o}, 32'd2);
        check("R4 write no drive", {30'd0, dq_drive}, 32'd0);
        rd_word(19'd5, 1'b0, 1'b0);
        check("R3 read mode", {30'd0, mode_o}, 32'd1);
        check("R3 read drive", {30'd0, dq_drive}, 32'd3);
        check("R3 read data", {16'd0, dq_out}, 32'hA55A);
    endtask

    task automatic t_lanes();
        wr_word(19'd5, 16'h1234, 1'b0, 1'b1);   // high lane only
        rd_word(19'd5, 1'b1, 1'b0);
        check("R3 low lane drive", {30'd0, dq_drive}, 32'd1);
        check("R8 low lane only data", {16'd0, dq_out}, 32'h005A);
        rd_word(19'd5, 1'b0, 1'b1);
        check("R4 high lane merged", {16'd0, dq_out}, 32'h1200);
        check("R3 high lane drive", {30'd0, dq_drive}, 32'd2);
    endtask

    task automatic t_write_with_oe();
        access(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 19'd6, 16'hBEEF);
        check("R4 write over oe mode", {30'd0, mode_o}, 32'd2);
        check("R4 write over oe drive", {30'd0, dq_drive}, 32'd0);
        rd_word(19'd6, 1'b0, 1'b0);
        check("R4 write over oe data", {16'd0, dq_out}, 32'hBEEF);
    endtask

    task automatic t_hold();
        access(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 19'd6, 16'h0000);
        check("R5 hold mode", {30'd0, mode_o}, 32'd3);
        check("R5 hold drive", {30'd0, dq_drive}, 32'd0);
        access(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 19'd6, 16'h0000);
        check("R5 hold any lanes", {30'd0, mode_o}, 32'd3);
        rd_word(19'd6, 1'b0, 1'b0);
        check("R5 hold no write", {16'd0, dq_out}, 32'hBEEF);
    endtask

    task automatic t_standby();
        access(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 19'd6, 16'h1111);
        check("R2 sel1 high mode", {30'd0, mode_o}, 32'd0);
        check("R2 sel1 high drive", {30'd0, dq_drive}, 32'd0);
        access(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 19'd6, 16'h2222);
        check("R2 sel2 low mode", {30'd0, mode_o}, 32'd0);
        access(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 19'd6, 16'h3333);
        check("R2 lanes off mode", {30'd0, mode_o}, 32'd0);
        rd_word(19'd6, 1'b0, 1'b0);
        check("R2 standby no write", {16'd0, dq_out}, 32'hBEEF);
    endtask

    task automatic t_byte_mode();
        // lane enables high and junk on dq_in[14:8]: must not matter (R7)
        access(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 19'd7, 16'h7F3C);
        check("R7 byte write mode", {30'd0, mode_o}, 32'd2);
        access(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 19'd7, 16'hD5C3);
        access(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 19'd7, 16'h0000);
        check("R6 byte read low", {16'd0, dq_out}, 32'h003C);
        check("R6 byte drive", {30'd0, dq_drive}, 32'd1);
        access(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 19'd7, 16'h8000);
        check("R6 byte read high", {16'd0, dq_out}, 32'h00C3);
        rd_word(19'd7, 1'b0, 1'b0);
        check("R6 byte order in word", {16'd0, dq_out}, 32'hC33C);
    endtask

    task automatic t_alias();
        wr_word(19'd9, 16'h0F0F, 1'b0, 1'b0);
        rd_word(19'(9 + DEPTH), 1'b0, 1'b0);
        check("R9 alias", {16'd0, dq_out}, 32'h0F0F);
    endtask

    task automatic t_write_then_off();
        wr_word(19'd10, 16'h5555, 1'b0, 1'b0);
        access(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 19'd10, 16'h0000);
        check("R10 off after write drive", {30'd0, dq_drive}, 32'd0);
        check("R10 off after write mode", {30'd0, mode_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_rw();
        t_lanes();
        t_write_with_oe();
        t_hold();
        t_standby();
        t_byte_mode();
        t_alias();
        t_write_then_off();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule